// File: doc/BRIEF.md
# Command-Queued SPI Master

This block is an SPI bus master fed by a short queue of command words. Each word holds up to 16 bits of payload plus its own routing and framing controls: which chip-select lines to drive, which of the timing sets to use, and whether chip select stays asserted once the frame ends. The engine pops a word, clocks it out on MOSI while it samples MISO, and pushes the received bits into a receive queue. Every frame yields exactly one receive entry, so a write-only transfer still has to be drained. A read-only transfer is a word with zero payload.

Words enter through a valid/ready stream. `tx_ready` is low while the transmit queue is full, and a word transfers on a clock edge where both `tx_valid` and `tx_ready` are high. Received words leave through a second valid/ready stream. `rx_valid` is high while the receive queue holds data, and an entry is removed on an edge where `rx_ready` is also high. No new frame starts while the receive queue is full, so the receive side throttles the engine and no data is lost.

A small control register holds halt, master enable and one idle-level bit per chip select. Its write cycle can also flush either queue. Status outputs report both fill counts and a running flag.

Top module: `cq_spi_master`

## Requirements
- R1: The transmit queue holds 4 words. `tx_ready` is low exactly when 4 words are held, a word offered then is not stored, and `tx_count` always equals the number of stored words.
- R2: A command word is laid out as payload in bits [15:0], chip-select map in bits [21:16] (bit 16 selects line 0), timing-set select in bit 22 and continue flag in bit 23.
- R3: Each timing set holds a 4-bit length field equal to frame bits minus one: 7 gives 8-bit frames, 15 gives 16-bit frames and 11 gives 12-bit frames. The set's fields are captured when a frame starts, so later changes affect only later frames.
- R4: The clock polarity, clock phase and LSB-first bits of a timing set act independently. SCK rests at the captured polarity. With phase 0, MISO is sampled on each leading edge and MOSI changes on trailing edges. With phase 1, MOSI changes on leading edges and MISO is sampled on trailing edges. MOSI is 0 outside frames.
- R5: A frame asserts the lines in its chip-select map. If the word's continue flag is 1, they stay asserted after the frame, until a later frame ends with the flag at 0.
- R6: `cs_line[i]` equals idle bit i when line i is not asserted and its inverse when it is asserted. After reset all idle bits are 1, so every line rests high.
- R7: A frame starts only while the block is enabled and not halted, and `running` reports exactly that, from the clock edge after the control write. A frame already in progress completes even if halt is set.
- R8: A control write with a flush bit set empties that queue on the same edge. Words pushed or received on that edge are dropped, and the flush takes effect only on that one write.
- R9: Each frame pushes one receive word, with the sampled bits right-aligned and the unused upper bits 0. No frame starts while the receive queue (4 entries) is full.
- R10: SCK holds each level for HALF_DIV clock cycles. Chip select leads the first SCK edge by one half period and trails the last edge by one half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_halt | input | 1 | Halt value to write |
| ctrl_enable | input | 1 | Master enable value to write |
| ctrl_cs_idle | input | 6 | Per-line idle level to write |
| ctrl_flush_tx | input | 1 | Empty the transmit queue on this write |
| ctrl_flush_rx | input | 1 | Empty the receive queue on this write |
| tset_len_m1 | input | 8 | Frame length minus one, 4 bits per timing set |
| tset_cpol | input | 2 | Clock polarity per timing set |
| tset_cpha | input | 2 | Clock phase per timing set |
| tset_lsb | input | 2 | LSB-first per timing set |
| tx_valid | input | 1 | Command word offered |
| tx_ready | output | 1 | Transmit queue can accept |
| tx_word | input | 24 | Command word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the received word |
| rx_data | output | 16 | Received word |
| tx_count | output | 3 | Transmit queue fill |
| rx_count | output | 3 | Receive queue fill |
| running | output | 1 | Enabled and not halted |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_line | output | 6 | Chip-select lines |

## Verification
The engine is tried with 8-, 12- and 16-bit frames under every polarity and phase pairing and both bit orders. MISO carries a pseudo-random stream, so a wrong sampling edge or a reversed bit order shows up as a different received word. Back-to-back words with and without the continue flag, and with changing chip-select maps, separate a held select from a released one. Changing the idle levels while a word is in flight shows whether the level is applied per line. Filling the receive queue, halting with words queued and flushing each queue on its own show whether the engine stalls only for the right cause and keeps no stale entries.

// File: rtl/cq_spi_pkg.sv
package cq_spi_pkg;
  localparam int DATA_W = 16;
  localparam int LEN_W  = 4;

  typedef struct packed {
    logic [LEN_W-1:0] len_m1;
    logic             cpol;
    logic             cpha;
    logic             lsb_first;
  } tcfg_t;
endpackage

// File: rtl/cq_spi_fifo.sv
module cq_spi_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign rdata   = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else if (clear) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!clear && do_push) mem[wp] <= wdata;
  end
endmodule

// File: rtl/cq_spi_engine.sv
module cq_spi_engine
  import cq_spi_pkg::*;
#(
  parameter int NCS      = 6,
  parameter int NTS      = 2,
  parameter int HALF_DIV = 2,
  localparam int TS_W    = (NTS > 1) ? $clog2(NTS) : 1,
  localparam int EW      = $clog2(2 * DATA_W + 1),
  localparam int TW      = $clog2(HALF_DIV + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_ok,
  input  logic              tx_has,
  input  logic              rx_space,
  input  logic [DATA_W-1:0] w_data,
  input  logic [NCS-1:0]    w_cs,
  input  logic [TS_W-1:0]   w_tsel,
  input  logic              w_cont,
  input  tcfg_t [NTS-1:0]   tcfg,
  input  logic [NCS-1:0]    cs_idle,
  input  logic              miso,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi,
  output logic [NCS-1:0]    cs_line,
  output logic              busy
);
  logic              busy_q, cont_q;
  logic [TW-1:0]     timer_q;
  logic [EW-1:0]     ec_q, edges2, kraw;
  tcfg_t             cfg_q, sel_cfg;
  logic [DATA_W-1:0] data_q, rxsh_q;
  logic [NCS-1:0]    act_q;
  logic [LEN_W-1:0]  kc, idx;
  logic              start, tick, more;

  assign sel_cfg = (int'(w_tsel) < NTS) ? tcfg[w_tsel] : tcfg[0];
  assign start   = ~busy_q & go_ok & tx_has & rx_space;
  assign tick    = busy_q & (timer_q == '0);
  assign edges2  = (EW'(cfg_q.len_m1) + EW'(1)) << 1;
  assign more    = ec_q < edges2;

  // Bit position from the number of SCK edges already made.
  always_comb begin
    if (cfg_q.cpha) kraw = (ec_q == '0) ? '0 : ((ec_q - EW'(1)) >> 1);
    else            kraw = ec_q >> 1;
    kc  = (kraw > EW'(cfg_q.len_m1)) ? cfg_q.len_m1 : kraw[LEN_W-1:0];
    idx = cfg_q.lsb_first ? kc : cfg_q.len_m1 - kc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      cont_q  <= 1'b0;
      timer_q <= '0;
      ec_q    <= '0;
      cfg_q   <= '0;
      data_q  <= '0;
      rxsh_q  <= '0;
      act_q   <= '0;
    end else if (start) begin
      busy_q  <= 1'b1;
      timer_q <= TW'(HALF_DIV - 1);
      ec_q    <= '0;
      cfg_q   <= sel_cfg;
      data_q  <= w_data;
      rxsh_q  <= '0;
      act_q   <= w_cs;
      cont_q  <= w_cont;
    end else if (tick) begin
      if (more) begin
        ec_q    <= ec_q + EW'(1);
        timer_q <= TW'(HALF_DIV - 1);
        if (ec_q[0] == cfg_q.cpha) rxsh_q[idx] <= miso;
      end else begin
        busy_q <= 1'b0;
        if (!cont_q) act_q <= '0;
      end
    end else if (busy_q) begin
      timer_q <= timer_q - TW'(1);
    end
  end

  assign tx_pop  = start;
  assign rx_push = tick & ~more;
  assign rx_word = rxsh_q;
  assign sck     = cfg_q.cpol ^ (busy_q & ec_q[0]);
  assign mosi    = busy_q & data_q[idx];
  assign cs_line = cs_idle ^ act_q;
  assign busy    = busy_q;
endmodule

// File: rtl/cq_spi_master.sv
module cq_spi_master
  import cq_spi_pkg::*;
#(
  parameter int NCS      = 6,
  parameter int NTS      = 2,
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int HALF_DIV = 2,
  localparam int TS_W    = (NTS > 1) ? $clog2(NTS) : 1,
  localparam int CMD_W   = DATA_W + NCS + TS_W + 1,
  localparam int TCW     = $clog2(TX_DEPTH + 1),
  localparam int RCW     = $clog2(RX_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrl_we,
  input  logic                 ctrl_halt,
  input  logic                 ctrl_enable,
  input  logic [NCS-1:0]       ctrl_cs_idle,
  input  logic                 ctrl_flush_tx,
  input  logic                 ctrl_flush_rx,
  input  logic [NTS*LEN_W-1:0] tset_len_m1,
  input  logic [NTS-1:0]       tset_cpol,
  input  logic [NTS-1:0]       tset_cpha,
  input  logic [NTS-1:0]       tset_lsb,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [CMD_W-1:0]     tx_word,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic [DATA_W-1:0]    rx_data,
  output logic [TCW-1:0]       tx_count,
  output logic [RCW-1:0]       rx_count,
  output logic                 running,
  output logic                 sck,
  output logic                 mosi,
  input  logic                 miso,
  output logic [NCS-1:0]       cs_line
);
  logic           halt_q, en_q;
  logic [NCS-1:0] idle_q;
  logic           flush_tx, flush_rx;
  logic           tx_full, tx_empty, rx_full, rx_empty;
  logic           eng_pop, eng_push, eng_busy;
  logic [CMD_W-1:0]  tx_head;
  logic [DATA_W-1:0] eng_rx_word;
  tcfg_t [NTS-1:0]   tcfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b1;
      en_q   <= 1'b0;
      idle_q <= '1;
    end else if (ctrl_we) begin
      halt_q <= ctrl_halt;
      en_q   <= ctrl_enable;
      idle_q <= ctrl_cs_idle;
    end
  end

  assign flush_tx = ctrl_we & ctrl_flush_tx;
  assign flush_rx = ctrl_we & ctrl_flush_rx;
  assign running  = en_q & ~halt_q;

  for (genvar g = 0; g < NTS; g++) begin : g_tset
    assign tcfg[g] = {tset_len_m1[g*LEN_W +: LEN_W], tset_cpol[g], tset_cpha[g], tset_lsb[g]};
  end

  cq_spi_fifo #(.W(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .clear(flush_tx), .push(tx_valid), .wdata(tx_word),
    .pop(eng_pop), .rdata(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  cq_spi_fifo #(.W(DATA_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clear(flush_rx), .push(eng_push), .wdata(eng_rx_word),
    .pop(rx_ready), .rdata(rx_data), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  cq_spi_engine #(.NCS(NCS), .NTS(NTS), .HALF_DIV(HALF_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .go_ok(running), .tx_has(~tx_empty), .rx_space(~rx_full),
    .w_data(tx_head[DATA_W-1:0]), .w_cs(tx_head[DATA_W +: NCS]),
    .w_tsel(tx_head[DATA_W+NCS +: TS_W]), .w_cont(tx_head[CMD_W-1]),
    .tcfg(tcfg), .cs_idle(idle_q), .miso(miso),
    .tx_pop(eng_pop), .rx_push(eng_push), .rx_word(eng_rx_word),
    .sck(sck), .mosi(mosi), .cs_line(cs_line), .busy(eng_busy)
  );

  assign tx_ready = ~tx_full;
  assign rx_valid = ~rx_empty;
endmodule

// File: rtl/cq_spi_checker.sv
module cq_spi_checker #(
  parameter int TX_DEPTH = 4,
  parameter int RX_DEPTH = 4,
  parameter int TCW      = 3,
  parameter int RCW      = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ctrl_we,
  input logic           ctrl_flush_tx,
  input logic           ctrl_flush_rx,
  input logic           tx_ready,
  input logic [TCW-1:0] tx_count,
  input logic [RCW-1:0] rx_count,
  input logic           running,
  input logic           busy,
  input logic           sck
);
  // R1: a full transmit queue refuses words
  a_r1_full_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == TCW'(TX_DEPTH)) |-> !tx_ready);

  // R7: no frame begins while stopped
  a_r7_no_start_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !running) |=> !busy);

  // R10: SCK is quiet between frames
  a_r10_sck_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(sck));

  // R8: flush empties each queue
  a_r8_flush_tx: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_flush_tx) |=> (tx_count == '0));

  a_r8_flush_rx: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_flush_rx) |=> (rx_count == '0));

  // R9: receive fill never exceeds its depth
  a_r9_rx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= RCW'(RX_DEPTH));
endmodule

bind cq_spi_master cq_spi_checker #(
  .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .TCW(TCW), .RCW(RCW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_flush_tx(ctrl_flush_tx),
  .ctrl_flush_rx(ctrl_flush_rx), .tx_ready(tx_ready), .tx_count(tx_count),
  .rx_count(rx_count), .running(running), .busy(eng_busy), .sck(sck)
);

// File: tb/cq_spi_master_test.sv
`timescale 1ns/1ps
module cq_spi_master_test;
  localparam int H   = 2;
  localparam int TXD = 4;
  localparam int RXD = 4;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        ctrl_we = 0, ctrl_halt = 0, ctrl_enable = 0;
  logic [5:0]  ctrl_cs_idle = 6'h3F;
  logic        ctrl_flush_tx = 0, ctrl_flush_rx = 0;
  logic [7:0]  tset_len_m1 = 8'hF7;
  logic [1:0]  tset_cpol = 2'b10, tset_cpha = 2'b10, tset_lsb = 2'b10;
  logic        tx_valid = 0;
  logic        tx_ready;
  logic [23:0] tx_word = '0;
  logic        rx_valid;
  logic        rx_ready = 1;
  logic [15:0] rx_data;
  logic [2:0]  tx_count, rx_count;
  logic        running, sck, mosi, cs_unused;
  logic        miso = 0;
  logic [5:0]  cs_line;

  int n_chk = 0, n_err = 0;
  bit done_flag = 0;

  always #10 clk = ~clk;

  cq_spi_master uut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_halt(ctrl_halt),
    .ctrl_enable(ctrl_enable), .ctrl_cs_idle(ctrl_cs_idle), .ctrl_flush_tx(ctrl_flush_tx),
    .ctrl_flush_rx(ctrl_flush_rx), .tset_len_m1(tset_len_m1), .tset_cpol(tset_cpol),
    .tset_cpha(tset_cpha), .tset_lsb(tset_lsb), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_word(tx_word), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_count(tx_count), .rx_count(rx_count), .running(running), .sck(sck), .mosi(mosi),
    .miso(miso), .cs_line(cs_line)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  // pseudo-random MISO stream
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso = lfsr[0];
  end

  // ---------------- behavioural reference model ----------------
  logic [23:0] mq_tx[$];
  logic [15:0] mq_rx[$];
  bit          m_busy, m_cont, m_halt, m_en, m_cpol, m_cpha, m_lsb;
  logic [5:0]  m_idle, m_act;
  logic [15:0] m_data, m_rxsh;
  int          m_tm, m_len;

  function automatic int idx_of(input int e);
    int k;
    if (m_cpha) k = (e == 0) ? 0 : (e - 1) / 2;
    else        k = e / 2;
    if (k > m_len - 1) k = m_len - 1;
    return m_lsb ? k : (m_len - 1 - k);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit start, accept, rxpop, fin;
    int txn, j, ts;
    logic [23:0] w;
    if (!rst_n) begin
      mq_tx.delete(); mq_rx.delete();
      m_busy = 0; m_cont = 0; m_halt = 1; m_en = 0; m_cpol = 0; m_cpha = 0; m_lsb = 0;
      m_idle = 6'h3F; m_act = 0; m_data = 0; m_rxsh = 0; m_tm = 0; m_len = 1;
    end else begin
      txn    = mq_tx.size();
      start  = !m_busy && m_en && !m_halt && txn > 0 && mq_rx.size() < RXD;
      accept = tx_valid && txn < TXD;
      rxpop  = rx_ready && mq_rx.size() > 0;
      fin    = 0;
      if (m_busy) begin
        m_tm++;
        if (m_tm % H == 0) begin
          j = m_tm / H - 1;
          if (j < 2 * m_len) begin
            if ((j % 2) == m_cpha) m_rxsh[idx_of(j)] = miso;
          end else begin
            fin = 1; m_busy = 0;
            if (!m_cont) m_act = 0;
          end
        end
      end
      if (start) begin
        w = mq_tx[0];
        ts = w[22];
        m_len  = tset_len_m1[ts*4 +: 4] + 1;
        m_cpol = tset_cpol[ts]; m_cpha = tset_cpha[ts]; m_lsb = tset_lsb[ts];
        m_data = w[15:0]; m_act = w[21:16]; m_cont = w[23];
        m_rxsh = 0; m_tm = 0; m_busy = 1;
      end
      if (ctrl_we && ctrl_flush_rx) mq_rx.delete();
      else begin
        if (rxpop) void'(mq_rx.pop_front());
        if (fin) mq_rx.push_back(m_rxsh);
      end
      if (ctrl_we && ctrl_flush_tx) mq_tx.delete();
      else begin
        if (start) void'(mq_tx.pop_front());
        if (accept) mq_tx.push_back(tx_word);
      end
      if (ctrl_we) begin
        m_halt = ctrl_halt; m_en = ctrl_enable; m_idle = ctrl_cs_idle;
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    int e;
    bit ex_sck, ex_mosi;
    if (rst_n && !done_flag) begin
      e = m_tm / H;
      if (e > 2 * m_len) e = 2 * m_len;
      ex_sck  = m_busy ? (m_cpol ^ e[0]) : m_cpol;
      ex_mosi = m_busy ? m_data[idx_of(e)] : 1'b0;
      chk(sck == ex_sck, "R10/R4 sck", sck, ex_sck);
      chk(mosi == ex_mosi, "R4/R2 mosi", mosi, ex_mosi);
      chk(cs_line == (m_idle ^ m_act), "R5/R6 cs_line", cs_line, m_idle ^ m_act);
      chk(tx_count == mq_tx.size(), "R1 tx_count", tx_count, mq_tx.size());
      chk(tx_ready == (mq_tx.size() < TXD), "R1 tx_ready", tx_ready, mq_tx.size() < TXD);
      chk(rx_count == mq_rx.size(), "R9 rx_count", rx_count, mq_rx.size());
      chk(running == (m_en && !m_halt), "R7 running", running, m_en && !m_halt);
      if (mq_rx.size() > 0) begin
        chk(rx_valid == 1'b1, "R9 rx_valid", rx_valid, 1);
        chk(rx_data == mq_rx[0], "R9/R3 rx_data", rx_data, mq_rx[0]);
      end else begin
        chk(rx_valid == 1'b0, "R9 rx_valid", rx_valid, 0);
      end
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [23:0] mk(input bit cont, input bit ts, input logic [5:0] cs,
                                     input logic [15:0] d);
    return {cont, ts, cs, d};
  endfunction

  task automatic push(input logic [23:0] w);
    do @(negedge clk); while (!tx_ready);
    #1 tx_valid = 1; tx_word = w;
    @(negedge clk); #1 tx_valid = 0;
  endtask

  task automatic push_try(input logic [23:0] w);
    @(negedge clk); #1 tx_valid = 1; tx_word = w;
    @(negedge clk); #1 tx_valid = 0;
  endtask

  task automatic wr_ctrl(input bit h, input bit en, input logic [5:0] idle,
                         input bit ftx, input bit frx);
    @(negedge clk); #1;
    ctrl_we = 1; ctrl_halt = h; ctrl_enable = en; ctrl_cs_idle = idle;
    ctrl_flush_tx = ftx; ctrl_flush_rx = frx;
    @(negedge clk); #1;
    ctrl_we = 0; ctrl_flush_tx = 0; ctrl_flush_rx = 0;
  endtask

  task automatic wait_drain();
    do @(negedge clk); while (tx_count != 0);
    repeat (80) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(cs_line == 6'h3F, "R6 reset idle high", cs_line, 6'h3F);
    chk(running == 0, "R7 reset halted", running, 0);
    chk(tx_count == 0, "R1 reset empty", tx_count, 0);
    chk(rx_valid == 0, "R9 reset no data", rx_valid, 0);

    // R1: fill while halted, fifth word refused
    for (int i = 0; i < 5; i++) push_try(mk(0, 0, 6'h01, 16'(i + 1)));
    @(negedge clk);
    chk(tx_count == 4, "R1 full count", tx_count, 4);
    chk(tx_ready == 0, "R1 full not ready", tx_ready, 0);
    // R8: flush, then flush does not repeat
    wr_ctrl(1, 0, 6'h3F, 1, 0);
    chk(tx_count == 0, "R8 tx flushed", tx_count, 0);
    push(mk(0, 0, 6'h01, 16'h0077));
    @(negedge clk);
    chk(tx_count == 1, "R8 flush self-clears", tx_count, 1);
    wr_ctrl(1, 0, 6'h3F, 1, 0);

    // set 0: 8 bits mode 0 msb; set 1: 16 bits cpol1 cpha1 lsb
    tset_len_m1 = 8'hF7; tset_cpol = 2'b10; tset_cpha = 2'b10; tset_lsb = 2'b10;
    wr_ctrl(0, 1, 6'h3F, 0, 0);
    chk(running == 1, "R7 running after enable", running, 1);

    // R5: continue flag holds select
    push(mk(1, 0, 6'h01, 16'h00A5));
    wait_drain();
    chk(cs_line == 6'h3E, "R5 select held", cs_line, 6'h3E);
    push(mk(0, 0, 6'h02, 16'h003C));
    wait_drain();
    chk(cs_line == 6'h3F, "R5 select released", cs_line, 6'h3F);

    // R6: per-line idle level
    wr_ctrl(0, 1, 6'b111011, 0, 0);
    chk(cs_line == 6'h3B, "R6 idle level", cs_line, 6'h3B);
    push(mk(0, 1, 6'h04, 16'h1234));
    push(mk(1, 1, 6'h10, 16'hBEEF));
    push(mk(0, 0, 6'h10, 16'h0081));
    wait_drain();

    // R3/R4: 12-bit lsb cpol1 cpha0, set changed mid-frame
    tset_len_m1[3:0] = 4'd11; tset_cpol[0] = 1; tset_cpha[0] = 0; tset_lsb[0] = 1;
    push(mk(0, 0, 6'h08, 16'h0ABC));
    repeat (10) @(negedge clk);
    tset_len_m1[3:0] = 4'd7; tset_cpol[0] = 0; tset_cpha[0] = 1; tset_lsb[0] = 0;
    wait_drain();
    // read-only frame, mode 1 msb
    push(mk(0, 0, 6'h20, 16'h0000));
    push(mk(0, 1, 6'h20, 16'h8001));
    wait_drain();

    // R9: receive queue full stalls frames
    #1 rx_ready = 0;
    for (int i = 0; i < 6; i++) push(mk(0, 0, 6'h01, 16'(8'h30 + i)));
    repeat (400) @(negedge clk);
    chk(rx_count == 4, "R9 rx full", rx_count, 4);
    chk(tx_count == 2, "R9 frames stalled", tx_count, 2);
    #1 rx_ready = 1;
    wait_drain();

    // R7: halt with words queued
    wr_ctrl(1, 1, 6'h3F, 0, 0);
    for (int i = 0; i < 3; i++) push(mk(0, 0, 6'h01, 16'h55));
    repeat (200) @(negedge clk);
    chk(tx_count == 3, "R7 halted holds queue", tx_count, 3);
    chk(running == 0, "R7 halted flag", running, 0);
    wr_ctrl(1, 1, 6'h3F, 1, 0);
    chk(tx_count == 0, "R8 flush while halted", tx_count, 0);

    // R8: receive flush
    #1 rx_ready = 0;
    wr_ctrl(0, 1, 6'h3F, 0, 0);
    push(mk(0, 0, 6'h01, 16'h11));
    push(mk(0, 0, 6'h01, 16'h22));
    wait_drain();
    chk(rx_count == 2, "R9 two received", rx_count, 2);
    wr_ctrl(0, 1, 6'h3F, 0, 1);
    chk(rx_count == 0, "R8 rx flushed", rx_count, 0);
    chk(rx_valid == 0, "R8 rx empty", rx_valid, 0);
    #1 rx_ready = 1;
    repeat (5) @(negedge clk);
    report();
  end
endmodule